// File: doc/BRIEF.md
# Single-Transfer DSP Address Generator

This block forms the memory address for one single-operand DSP load or store. The access may reach anywhere in the address space and may be a word (16 bits) or a longword (32 bits). The block does not own the pointer registers; their current values come in on `ptrs_i`. It picks one of four pointer registers and applies one of four update modes:

- keep the pointer unchanged;
- step the pointer up after the access;
- add the index register to the pointer after the access;
- step the pointer down before the access.

The step is 2 for a word and 4 for a longword. There is no modulo wrap-around window on this path. Pointer arithmetic simply wraps at the width of the address.

A request is captured into one output register stage. The resulting access waits on the shared data bus while `stall_i` is high. During that time the address and the pointer write-back are frozen, and new requests are not taken. The write-back strobe fires in the cycle the bus lets the access go. It names the architectural register to update, counting up from a base register number.

A misaligned effective address raises an error flag and blocks the write-back. A longword address is misaligned when its two low bits are not zero. A word address is misaligned when bit 0 is set.

Top module: `agu_single_xfer`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises with no request, `valid_o`, `wb_en_o` and `addr_err_o` are 0.
- R2: Mode 2'b00 (keep): `addr_o` and `wb_data_o` both equal the selected pointer.
- R3: Mode 2'b01 (post-increment): `addr_o` is the selected pointer, and `wb_data_o` is that pointer plus 2 when `long_i`=0 or plus 4 when `long_i`=1.
- R4: Mode 2'b10 (post-index): `addr_o` is the selected pointer, and `wb_data_o` is that pointer plus `idx_i`.
- R5: Mode 2'b11 (pre-decrement): `wb_data_o` is the selected pointer minus 2 (word) or minus 4 (longword), and `addr_o` equals that decremented value.
- R6: `sel_i` = k selects `ptrs_i[k]`. `wb_reg_o` reports register number RBASE + k, which is 2..5 by default.
- R7: A request taken at a clock edge appears on the outputs, with `valid_o`=1, right after that edge. `long_o` echoes `long_i`. With no request, `valid_o` is 0 after the next edge.
- R8: While `valid_o` and `stall_i` are both 1, `addr_o`, `wb_data_o`, `wb_reg_o`, `long_o` and `valid_o` stay unchanged. A request presented then is ignored, and `wb_en_o` stays 0.
- R9: `wb_en_o` is 1 exactly when `valid_o`=1, `stall_i`=0 and `addr_err_o`=0.
- R10: `addr_err_o` is 1 for a longword whose `addr_o[1:0]` is not 2'b00, or for a word with `addr_o[0]`=1. The check uses the effective address, so in pre-decrement mode it uses the decremented value.
- R11: Pointer arithmetic wraps modulo 2^AW. For example, pre-decrementing 0 by a word gives 2^AW-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| stall_i | input | 1 | Shared bus not yet granted |
| sel_i | input | $clog2(NPTR) | Pointer select |
| mode_i | input | 2 | Update mode: 00 keep, 01 post-inc, 10 post-index, 11 pre-dec |
| long_i | input | 1 | 1 = longword, 0 = word |
| ptrs_i | input | NPTR*AW | Current pointer register values, entry k at bits [k*AW +: AW] |
| idx_i | input | AW | Index register value |
| valid_o | output | 1 | Access pending on outputs |
| addr_o | output | AW | Effective address |
| long_o | output | 1 | Access size |
| addr_err_o | output | 1 | Misaligned effective address |
| wb_en_o | output | 1 | Pointer write-back strobe |
| wb_reg_o | output | RNW | Register number to write back |
| wb_data_o | output | AW | Updated pointer value |

## Verification
The bench builds the block with AW=16, keeping NPTR=4 and RBASE=2. The narrow address lets wrap-around at both ends of the pointer range, and a wrapping index addition, be reached with small constants. At the same time, the four-entry pointer set and register numbers 2 to 5 stay as in the default build. Each mode is run at both sizes and from every pointer. Alignment faults are provoked both from the pointer itself and from a decremented effective address. A stall is held across a competing request before it is released.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP     = 2'd0,
    MODE_POST_INC = 2'd1,
    MODE_POST_IDX = 2'd2,
    MODE_PRE_DEC  = 2'd3
  } agu_mode_e;

  typedef enum logic {
    SZ_WORD = 1'b0,
    SZ_LONG = 1'b1
  } agu_size_e;

  localparam int unsigned WORD_BYTES = 2;
  localparam int unsigned LONG_BYTES = 4;
endpackage

// File: rtl/agu_ptr_mux.sv
`timescale 1ns/1ps
module agu_ptr_mux #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NPTR = 4
) (
  input  logic [NPTR-1:0][AW-1:0]     ptrs_i,
  input  logic [$clog2(NPTR)-1:0]     sel_i,
  output logic [AW-1:0]               ptr_o
);
  logic [NPTR-1:0][AW-1:0] masked;

  // one-hot AND-OR select, avoids a deep priority chain
  for (genvar k = 0; k < NPTR; k++) begin : g_sel
    assign masked[k] = (sel_i == k[$clog2(NPTR)-1:0]) ? ptrs_i[k] : '0;
  end

  always_comb begin
    ptr_o = '0;
    for (int k = 0; k < NPTR; k++) ptr_o |= masked[k];
  end
endmodule

// File: rtl/agu_update.sv
`timescale 1ns/1ps
module agu_update
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] idx_i,
  input  agu_mode_e     mode_i,
  input  agu_size_e     size_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] next_o
);
  localparam logic [AW-1:0] STEP_W = AW'(WORD_BYTES);
  localparam logic [AW-1:0] STEP_L = AW'(LONG_BYTES);

  logic [AW-1:0] step_mag;
  logic [AW-1:0] addend;

  assign step_mag = (size_i == SZ_LONG) ? STEP_L : STEP_W;

  // single adder, operand muxed per mode
  always_comb begin
    unique case (mode_i)
      MODE_KEEP:     addend = '0;
      MODE_POST_INC: addend = step_mag;
      MODE_POST_IDX: addend = idx_i;
      MODE_PRE_DEC:  addend = (~step_mag) + AW'(1);
      default:       addend = '0;
    endcase
  end

  assign next_o = ptr_i + addend;
  assign ea_o   = (mode_i == MODE_PRE_DEC) ? next_o : ptr_i;
endmodule

// File: rtl/agu_align.sv
`timescale 1ns/1ps
module agu_align
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] ea_i,
  input  agu_size_e     size_i,
  output logic          err_o
);
  logic [1:0] low_mask;

  assign low_mask = (size_i == SZ_LONG) ? 2'b11 : 2'b01;
  assign err_o    = |(ea_i[1:0] & low_mask);
endmodule

// File: rtl/agu_single_xfer.sv
`timescale 1ns/1ps
module agu_single_xfer
  import agu_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NPTR  = 4,
  parameter int unsigned RBASE = 2,
  parameter int unsigned RNW   = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        stall_i,
  input  logic [$clog2(NPTR)-1:0]     sel_i,
  input  logic [1:0]                  mode_i,
  input  logic                        long_i,
  input  logic [NPTR-1:0][AW-1:0]     ptrs_i,
  input  logic [AW-1:0]               idx_i,
  output logic                        valid_o,
  output logic [AW-1:0]               addr_o,
  output logic                        long_o,
  output logic                        addr_err_o,
  output logic                        wb_en_o,
  output logic [RNW-1:0]              wb_reg_o,
  output logic [AW-1:0]               wb_data_o
);
  localparam int unsigned SW = $clog2(NPTR);

  agu_mode_e     mode;
  agu_size_e     size;
  logic [AW-1:0] ptr_sel;
  logic [AW-1:0] ea_d;
  logic [AW-1:0] next_d;
  logic          err_d;
  logic          hold;

  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] wb_data_q;
  logic [RNW-1:0] wb_reg_q;
  logic          long_q;
  logic          err_q;

  assign mode = agu_mode_e'(mode_i);
  assign size = agu_size_e'(long_i);

  agu_ptr_mux #(.AW(AW), .NPTR(NPTR)) u_mux (
    .ptrs_i (ptrs_i),
    .sel_i  (sel_i),
    .ptr_o  (ptr_sel)
  );

  agu_update #(.AW(AW)) u_upd (
    .ptr_i  (ptr_sel),
    .idx_i  (idx_i),
    .mode_i (mode),
    .size_i (size),
    .ea_o   (ea_d),
    .next_o (next_d)
  );

  agu_align #(.AW(AW)) u_aln (
    .ea_i   (ea_d),
    .size_i (size),
    .err_o  (err_d)
  );

  // freeze the stage while the bus has not granted the pending access
  assign hold = valid_q & stall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      addr_q    <= '0;
      wb_data_q <= '0;
      wb_reg_q  <= '0;
      long_q    <= 1'b0;
      err_q     <= 1'b0;
    end else if (!hold) begin
      valid_q <= req_i;
      if (req_i) begin
        addr_q    <= ea_d;
        wb_data_q <= next_d;
        wb_reg_q  <= RNW'(RBASE) + RNW'(sel_i);
        long_q    <= long_i;
        err_q     <= err_d;
      end else begin
        err_q <= 1'b0;
      end
    end
  end

  assign valid_o    = valid_q;
  assign addr_o     = addr_q;
  assign long_o     = long_q;
  assign addr_err_o = err_q;
  assign wb_reg_o   = wb_reg_q;
  assign wb_data_o  = wb_data_q;
  assign wb_en_o    = valid_q & ~stall_i & ~err_q;

  logic unused_sw;
  assign unused_sw = ^SW;
endmodule

// File: rtl/agu_single_xfer_chk.sv
`timescale 1ns/1ps
module agu_single_xfer_chk #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NPTR = 4,
  parameter int unsigned RNW  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    stall_i,
  input logic [$clog2(NPTR)-1:0] sel_i,
  input logic [1:0]              mode_i,
  input logic                    long_i,
  input logic [NPTR-1:0][AW-1:0] ptrs_i,
  input logic [AW-1:0]           idx_i,
  input logic                    valid_o,
  input logic [AW-1:0]           addr_o,
  input logic                    long_o,
  input logic                    addr_err_o,
  input logic                    wb_en_o,
  input logic [RNW-1:0]          wb_reg_o,
  input logic [AW-1:0]           wb_data_o
);
  logic take;
  assign take = req_i & ~(valid_o & stall_i);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (!valid_o && !wb_en_o && !addr_err_o);
    end
  end

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (valid_o && long_o == $past(long_i)));

  a_r5_predec_ea: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode_i == 2'b11) |=> (addr_o == wb_data_o));

  a_r3_postinc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode_i == 2'b01) |=> (wb_data_o - addr_o == (long_o ? AW'(4) : AW'(2))));

  a_r2_keep_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode_i == 2'b00) |=> (wb_data_o == addr_o));

  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stall_i) |=> (valid_o && $stable(addr_o) && $stable(wb_data_o)
                              && $stable(wb_reg_o) && $stable(long_o)));

  a_r8_no_wb_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !wb_en_o);

  a_r10_err_blocks_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> !wb_en_o);

  a_r10_aligned_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !addr_err_o) |-> (long_o ? (addr_o[1:0] == 2'b00) : !addr_o[0]));

  a_r9_wb_when_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !stall_i && !addr_err_o) |-> wb_en_o);

  logic unused;
  assign unused = ^{sel_i, ptrs_i, idx_i};
endmodule

bind agu_single_xfer agu_single_xfer_chk #(.AW(AW), .NPTR(NPTR), .RNW(RNW)) u_chk (.*);

// File: tb/agu_single_xfer_bench.sv
`timescale 1ns/1ps
module agu_single_xfer_bench;
  localparam int unsigned AW = 16;
  localparam int unsigned NPTR = 4;
  localparam int unsigned RNW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic stall = 1'b0;
  logic [1:0] sel = '0;
  logic [1:0] mode = '0;
  logic lng = 1'b0;
  logic [NPTR-1:0][AW-1:0] ptrs = '0;
  logic [AW-1:0] idx = '0;
  logic valid, long_out, aerr, wb_en;
  logic [AW-1:0] addr, wb_data;
  logic [RNW-1:0] wb_reg;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  agu_single_xfer #(.AW(AW), .NPTR(NPTR), .RBASE(2), .RNW(RNW)) u_agu_single_xfer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .stall_i(stall), .sel_i(sel),
    .mode_i(mode), .long_i(lng), .ptrs_i(ptrs), .idx_i(idx),
    .valid_o(valid), .addr_o(addr), .long_o(long_out), .addr_err_o(aerr),
    .wb_en_o(wb_en), .wb_reg_o(wb_reg), .wb_data_o(wb_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one request, check it one edge later
  task automatic go(input string tag, input logic [1:0] s, input logic [1:0] m,
                    input logic l, input logic [AW-1:0] ix);
    logic [AW-1:0] p, nx, ea;
    logic er;
    p = ptrs[s];
    case (m)
      2'b00: nx = p;
      2'b01: nx = p + (l ? 16'd4 : 16'd2);
      2'b10: nx = p + ix;
      default: nx = p - (l ? 16'd4 : 16'd2);
    endcase
    ea = (m == 2'b11) ? nx : p;
    er = l ? (ea[1:0] != 2'b00) : ea[0];
    @(negedge clk);
    req = 1'b1; sel = s; mode = m; lng = l; idx = ix; stall = 1'b0;
    @(negedge clk);
    req = 1'b0;
    #1;
    chk({tag, " valid"}, 32'(valid), 32'd1);
    chk({tag, " addr"}, 32'(addr), 32'(ea));
    chk({tag, " wb_data"}, 32'(wb_data), 32'(nx));
    chk({tag, " wb_reg"}, 32'(wb_reg), 32'(2 + s));
    chk({tag, " long"}, 32'(long_out), 32'(l));
    chk({tag, " err"}, 32'(aerr), 32'(er));
    chk({tag, " R9 wb_en"}, 32'(wb_en), 32'(!er));
  endtask

  task automatic t_reset();
    #1;
    chk("R1 valid in reset", 32'(valid), 0);
    chk("R1 wb_en in reset", 32'(wb_en), 0);
    chk("R1 err in reset", 32'(aerr), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 valid after reset", 32'(valid), 0);
    chk("R1 wb_en after reset", 32'(wb_en), 0);
  endtask

  task automatic t_modes();
    ptrs = {16'h4008, 16'h3000, 16'h2004, 16'h1000};
    go("R2 keep word", 2'd0, 2'b00, 1'b0, 16'h0);
    go("R2 keep long", 2'd2, 2'b00, 1'b1, 16'h0);
    go("R3 postinc word", 2'd1, 2'b01, 1'b0, 16'h0);
    go("R3 postinc long", 2'd3, 2'b01, 1'b1, 16'h0);
    go("R4 index", 2'd0, 2'b10, 1'b1, 16'h0123);
    go("R4 index neg", 2'd2, 2'b10, 1'b0, 16'hFFF0);
    go("R5 predec word", 2'd1, 2'b11, 1'b0, 16'h0);
    go("R5 predec long", 2'd3, 2'b11, 1'b1, 16'h0);
    @(negedge clk); #1;
    chk("R7 idle drops valid", 32'(valid), 0);
  endtask

  task automatic t_select();
    ptrs = {16'hA000, 16'hB000, 16'hC000, 16'hD000};
    for (int k = 0; k < 4; k++) go("R6 select", 2'(k), 2'b01, 1'b1, 16'h0);
  endtask

  task automatic t_wrap();
    ptrs = {16'hFFFC, 16'h0000, 16'hFFFE, 16'h0000};
    go("R11 predec wrap word", 2'd0, 2'b11, 1'b0, 16'h0);
    go("R11 predec wrap long", 2'd2, 2'b11, 1'b1, 16'h0);
    go("R11 postinc wrap", 2'd3, 2'b01, 1'b1, 16'h0);
    go("R11 index wrap", 2'd1, 2'b10, 1'b0, 16'h0010);
  endtask

  task automatic t_align();
    ptrs = {16'h1006, 16'h1001, 16'h1002, 16'h1000};
    go("R10 long bit1", 2'd1, 2'b01, 1'b1, 16'h0);
    go("R10 word bit0", 2'd2, 2'b00, 1'b0, 16'h0);
    go("R10 word bit1 ok", 2'd1, 2'b00, 1'b0, 16'h0);
    go("R10 predec ea", 2'd3, 2'b11, 1'b1, 16'h0);
    go("R10 odd index ok", 2'd0, 2'b10, 1'b1, 16'h0003);
  endtask

  task automatic t_stall();
    ptrs = {16'h4000, 16'h3000, 16'h2000, 16'h1000};
    @(negedge clk);
    req = 1'b1; sel = 2'd0; mode = 2'b01; lng = 1'b1; stall = 1'b1;
    @(negedge clk);
    sel = 2'd3; mode = 2'b11; lng = 1'b0;
    #1;
    chk("R8 stalled valid", 32'(valid), 1);
    chk("R8 stalled wb_en", 32'(wb_en), 0);
    chk("R8 stalled addr", 32'(addr), 32'h1000);
    @(negedge clk);
    req = 1'b0;
    #1;
    chk("R8 held addr", 32'(addr), 32'h1000);
    chk("R8 held wb_data", 32'(wb_data), 32'h1004);
    chk("R8 held wb_reg", 32'(wb_reg), 2);
    chk("R8 held long", 32'(long_out), 1);
    chk("R8 held wb_en", 32'(wb_en), 0);
    stall = 1'b0;
    #1;
    chk("R9 granted wb_en", 32'(wb_en), 1);
    @(negedge clk); #1;
    chk("R8 dropped req ignored", 32'(valid), 0);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_select();
    t_wrap();
    t_align();
    t_stall();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule